// File: doc/BRIEF.md
# Watchdog Timer with Second/Minute Unit Select

A down-counting watchdog configured through four byte-wide registers. Software picks the counting unit (seconds or minutes), the outputs that a timeout drives, and a start value. A nonzero start value arms the counter and zero disarms it. A free-running prescaler turns the system clock into a one-second tick. A further divide-by-`MIN_DIV` turns that into a minute tick.

Keepalive does not need a register write. Strobes from neighbouring peripherals can restore the programmed start value: a game-port read, a keyboard interrupt, a mouse interrupt, or an infrared-receiver interrupt. The infrared path takes effect only after a fixed delay. Each source has its own enable bit.

When the count runs out, a sticky flag is set. A pulse of `PULSE_W` cycles goes out on each output that is enabled. Software can also force a timeout at any time.

Top module: `unit_watchdog`

## Requirements
- R1: After a synchronous active-low reset, all registers read zero, `count_o` is zero and the three timeout outputs are low.
- R2: The register index selects the register: 0 is control, 1 is configuration, 2 is count low byte and 3 is count high byte. Control bits 7/6/5/4 are the source enables (infrared, mouse, keyboard, game-port read), bits 3:1 always read 0 and bit 0 is the timeout flag. Configuration and both count bytes read back exactly as written.
- R3: Writing either count byte loads the counter with {high,low} at the capturing edge. A loaded value of zero keeps the watchdog stopped with no timeout.
- R4: The free-running prescaler produces a second tick once every `TICK_CYC` cycles after reset. With configuration bit 7 = 1 the counter drops by one on each second tick. With bit 7 = 0 it drops by one on every `MIN_DIV`-th second tick.
- R5: A decrement from 1 to 0 is a timeout. From the next cycle, each output whose enable is set is high for `PULSE_W` cycles: configuration bit 6 enables `kb_reset_o`, bit 5 enables `timeout_o` and bit 4 enables `pwr_fail_o`.
- R6: After a timeout the counter holds at zero until a count write or a reload.
- R7: A game-port read, keyboard or mouse strobe whose enable bit is set reloads the counter with the programmed {high,low} value at the same edge. A strobe whose enable bit is clear has no effect.
- R8: An enabled infrared strobe reloads the counter exactly `IR_DLY` edges after the edge that captured it. A new strobe while one is pending restarts the delay.
- R9: The timeout flag is set by every timeout. It stays set until a control write with bit 0 = 0 clears it. A control write with bit 0 = 1 leaves it unchanged.
- R10: A control write with bit 1 = 1 acts as a timeout at its capturing edge: the flag is set, the counter goes to zero and the pulse starts. Bit 1 always reads 0.
- R11: Priority at an edge is count write, then forced timeout, then reload, then decrement. A reload at the edge where a tick would take the count from 1 to 0 prevents that timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register index |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read of the addressed register |
| gp_rd_stb | input | 1 | Game-port read strobe (reload source) |
| kbd_irq | input | 1 | Keyboard interrupt strobe (reload source) |
| mouse_irq | input | 1 | Mouse interrupt strobe (reload source) |
| ir_irq | input | 1 | Infrared-receiver interrupt strobe (delayed reload source) |
| count_o | output | 16 or 8 (`WIDE_CNT`) | Current counter value |
| kb_reset_o | output | 1 | Keyboard-reset timeout pulse |
| timeout_o | output | 1 | General timeout pulse |
| pwr_fail_o | output | 1 | Power-good timeout pulse |

## Verification
A register write shows on `reg_rdata` and `count_o` right after the edge that captures it. An immediate reload shows at the same edge. An infrared reload shows `IR_DLY` edges later. The timeout pulse rises one cycle after the expiring edge and lasts `PULSE_W` cycles. The bench steps a behavioural model at each rising edge using the inputs held since the preceding falling edge. It then compares every output 2 ns after that edge, so each result is checked in the cycle it is due. Directed phases target each requirement. A random phase follows, where writes, forced timeouts, reloads and ticks collide at the same edges.

// File: rtl/wdu_pkg.sv
// Shared definitions for the unit watchdog: register indices and bit positions.
package wdu_pkg;
    typedef enum logic [1:0] {
        IDX_CTRL   = 2'd0,
        IDX_CFG    = 2'd1,
        IDX_CNT_LO = 2'd2,
        IDX_CNT_HI = 2'd3
    } wdu_idx_e;

    localparam int CTL_FORCE = 1;
    localparam int CTL_FLAG  = 0;
    localparam int CFG_SEC   = 7;
    localparam int CFG_KRST  = 6;
    localparam int CFG_TOUT  = 5;
    localparam int CFG_PWR   = 4;
endpackage

// File: rtl/wdu_regs.sv
// Register bank of the unit watchdog.
// Holds source enables, timeout flag, configuration byte and start value.
// Assumes one register access per cycle; reads are combinational.
module wdu_regs
    import wdu_pkg::*;
#(
    parameter bit WIDE = 1'b1,
    localparam int CW  = WIDE ? 16 : 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          we,
    input  logic [7:0]    wdata,
    input  logic          expire_i,
    output logic [7:0]    rdata,
    output logic [3:0]    src_en,
    output logic          sec_mode,
    output logic          krst_en,
    output logic          tout_en,
    output logic          pwr_en,
    output logic          load_o,
    output logic          force_o,
    output logic [CW-1:0] load_val,
    output logic [CW-1:0] reload_val
);
    logic [3:0] en_q;
    logic       flag_q;
    logic [7:0] cfg_q;
    logic [7:0] lo_q;
    logic [7:0] hi_q;
    logic       wr_ctrl, wr_cfg, wr_lo, wr_hi;

    assign wr_ctrl = we && (addr == IDX_CTRL);
    assign wr_cfg  = we && (addr == IDX_CFG);
    assign wr_lo   = we && (addr == IDX_CNT_LO);
    assign wr_hi   = we && (addr == IDX_CNT_HI);

    // Source enables come from the upper control nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (wr_ctrl) en_q <= wdata[7:4];
    end

    // Timeout flag: set by expiry, cleared only by a control write with bit 0 low.
    always_ff @(posedge clk) begin
        if (!rst_n)                           flag_q <= 1'b0;
        else if (expire_i)                    flag_q <= 1'b1;
        else if (wr_ctrl && !wdata[CTL_FLAG]) flag_q <= 1'b0;
    end

    // Configuration byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= wdata;
    end

    // Start value low byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (wr_lo) lo_q <= wdata;
    end

    generate
        if (WIDE) begin : g_hi
            // Start value high byte, present only in the 16-bit build.
            always_ff @(posedge clk) begin
                if (!rst_n)     hi_q <= '0;
                else if (wr_hi) hi_q <= wdata;
            end
            assign load_val   = CW'(wr_lo ? {hi_q, wdata} : {wdata, lo_q});
            assign reload_val = CW'({hi_q, lo_q});
            assign load_o     = wr_lo || wr_hi;
        end else begin : g_no_hi
            assign hi_q       = '0;
            assign load_val   = CW'(wdata);
            assign reload_val = CW'(lo_q);
            assign load_o     = wr_lo;
        end
    endgenerate

    // Read multiplexer; force bit and bits 3:2 always read zero.
    always_comb begin
        case (addr)
            IDX_CTRL: rdata = {en_q, 3'b000, flag_q};
            IDX_CFG:  rdata = cfg_q;
            IDX_CNT_LO: rdata = lo_q;
            default:  rdata = hi_q;
        endcase
    end

    assign src_en   = en_q;
    assign sec_mode = cfg_q[CFG_SEC];
    assign krst_en  = cfg_q[CFG_KRST];
    assign tout_en  = cfg_q[CFG_TOUT];
    assign pwr_en   = cfg_q[CFG_PWR];
    assign force_o  = wr_ctrl && wdata[CTL_FORCE];

    assert_expire_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_q);
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !wr_ctrl) |=> flag_q);
endmodule

// File: rtl/wdu_tick.sv
// Prescaler of the unit watchdog.
// Produces a second tick every TICK_CYC cycles and a minute tick every MIN_DIV seconds.
// Free-running from reset; the unit tick follows the selected unit.
module wdu_tick #(
    parameter int TICK_CYC = 100_000_000,
    parameter int MIN_DIV  = 60,
    localparam int PSW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1,
    localparam int MW  = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_mode,
    output logic unit_tick
);
    localparam logic [PSW-1:0] PS_LAST = PSW'(TICK_CYC - 1);
    localparam logic [MW-1:0]  MC_LAST = MW'(MIN_DIV - 1);

    logic [PSW-1:0] presc_q;
    logic [MW-1:0]  min_q;
    logic           sec_tick, min_tick;

    assign sec_tick = (presc_q == PS_LAST);
    assign min_tick = sec_tick && (min_q == MC_LAST);

    // Cycle prescaler wrapping once per second.
    always_ff @(posedge clk) begin
        if (!rst_n)        presc_q <= '0;
        else if (sec_tick) presc_q <= '0;
        else               presc_q <= presc_q + PSW'(1);
    end

    // Second counter wrapping once per minute.
    always_ff @(posedge clk) begin
        if (!rst_n)        min_q <= '0;
        else if (min_tick) min_q <= '0;
        else if (sec_tick) min_q <= min_q + MW'(1);
    end

    assign unit_tick = sec_mode ? sec_tick : min_tick;

    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((TICK_CYC > 1) && sec_tick) |=> !sec_tick);
endmodule

// File: rtl/wdu_reload.sv
// Reload source combiner of the unit watchdog.
// Game-port, keyboard and mouse strobes reload at once.
// An infrared strobe reloads after IR_DLY edges. Assumes IR_DLY >= 1.
module wdu_reload #(
    parameter int IR_DLY = 500_000,
    localparam int DW = $clog2(IR_DLY + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] src_en,
    input  logic       gp_stb,
    input  logic       kbd_irq,
    input  logic       mouse_irq,
    input  logic       ir_irq,
    output logic       reload_o
);
    logic [DW-1:0] pend_q;
    logic          ir_go, ir_fire, imm;

    assign ir_go   = ir_irq && src_en[3];
    assign ir_fire = (pend_q == DW'(1));
    assign imm     = (gp_stb && src_en[0]) || (kbd_irq && src_en[1]) || (mouse_irq && src_en[2]);

    // Delay counter for the infrared path; a new strobe restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)               pend_q <= '0;
        else if (ir_go)           pend_q <= DW'(IR_DLY);
        else if (pend_q != '0)    pend_q <= pend_q - DW'(1);
    end

    assign reload_o = imm || ir_fire;

    assert_ir_not_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((IR_DLY > 1) && ir_go) |=> !ir_fire);
endmodule

// File: rtl/unit_watchdog.sv
// Unit watchdog top: down-counter, timeout detection and output pulse generation.
// Counts in seconds or minutes and reloads from peripheral strobes.
// Assumes strobes are synchronous single-cycle pulses.
module unit_watchdog #(
    parameter bit WIDE_CNT = 1'b1,
    parameter int TICK_CYC = 100_000_000,
    parameter int MIN_DIV  = 60,
    parameter int PULSE_W  = 16,
    parameter int IR_DLY   = 500_000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    reg_addr,
    input  logic                          reg_we,
    input  logic [7:0]                    reg_wdata,
    output logic [7:0]                    reg_rdata,
    input  logic                          gp_rd_stb,
    input  logic                          kbd_irq,
    input  logic                          mouse_irq,
    input  logic                          ir_irq,
    output logic [(WIDE_CNT ? 16 : 8)-1:0] count_o,
    output logic                          kb_reset_o,
    output logic                          timeout_o,
    output logic                          pwr_fail_o
);
    localparam int CW  = WIDE_CNT ? 16 : 8;
    localparam int PCW = $clog2(PULSE_W + 1);

    logic [CW-1:0]  cnt_q, load_val, reload_val;
    logic [PCW-1:0] pulse_q;
    logic [3:0]     src_en;
    logic           sec_mode, krst_en, tout_en, pwr_en;
    logic           load, force_exp, reload, unit_tick, expire, active;

    wdu_regs #(.WIDE(WIDE_CNT)) i_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
        .expire_i(expire), .rdata(reg_rdata), .src_en(src_en), .sec_mode(sec_mode),
        .krst_en(krst_en), .tout_en(tout_en), .pwr_en(pwr_en), .load_o(load),
        .force_o(force_exp), .load_val(load_val), .reload_val(reload_val)
    );

    wdu_tick #(.TICK_CYC(TICK_CYC), .MIN_DIV(MIN_DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .sec_mode(sec_mode), .unit_tick(unit_tick)
    );

    wdu_reload #(.IR_DLY(IR_DLY)) i_reload (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .gp_stb(gp_rd_stb),
        .kbd_irq(kbd_irq), .mouse_irq(mouse_irq), .ir_irq(ir_irq), .reload_o(reload)
    );

    assign expire = force_exp || (!load && !reload && unit_tick && (cnt_q == CW'(1)));

    // Down-counter: write, then force, then reload, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (load)                       cnt_q <= load_val;
        else if (force_exp)                  cnt_q <= '0;
        else if (reload)                     cnt_q <= reload_val;
        else if (unit_tick && cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end

    // Timeout pulse width counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              pulse_q <= '0;
        else if (expire)         pulse_q <= PCW'(PULSE_W);
        else if (pulse_q != '0)  pulse_q <= pulse_q - PCW'(1);
    end

    assign active     = (pulse_q != '0);
    assign count_o    = cnt_q;
    assign kb_reset_o = active && krst_en;
    assign timeout_o  = active && tout_en;
    assign pwr_fail_o = active && pwr_en;

    assert_load_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));
    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && unit_tick && !load && !reload && !force_exp) |=> (cnt_q == $past(cnt_q) - CW'(1)));
    assert_pulse_routing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (kb_reset_o == krst_en && timeout_o == tout_en && pwr_fail_o == pwr_en));
    assert_hold_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load && !reload) |=> (cnt_q == '0));
    assert_reload_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !load && !force_exp) |=> (cnt_q == $past(reload_val)));
    assert_force_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (force_exp && !load) |=> (cnt_q == '0));
endmodule

// File: tb/test_unit_watchdog.sv
`timescale 1ns/100ps
module test_unit_watchdog;
    localparam int TICK = 4;
    localparam int PW   = 3;
    localparam int DLY  = 5;
    localparam int MDIV = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        gp_rd_stb = 1'b0, kbd_irq = 1'b0, mouse_irq = 1'b0, ir_irq = 1'b0;
    logic [15:0] count_o;
    logic        kb_reset_o, timeout_o, pwr_fail_o;

    always #2.5 clk = ~clk;

    unit_watchdog #(.WIDE_CNT(1'b1), .TICK_CYC(TICK), .MIN_DIV(MDIV), .PULSE_W(PW), .IR_DLY(DLY))
    i_unit_watchdog (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gp_rd_stb(gp_rd_stb), .kbd_irq(kbd_irq), .mouse_irq(mouse_irq),
        .ir_irq(ir_irq), .count_o(count_o), .kb_reset_o(kb_reset_o), .timeout_o(timeout_o),
        .pwr_fail_o(pwr_fail_o)
    );

    int    total = 0, bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int       m_ec, m_cnt, m_pulse, m_pend;
    bit [3:0] m_en;
    bit       m_flag;
    bit [7:0] m_cfg, m_lo, m_hi;

    task automatic chk(string req, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model_step();
        bit sec, mn, ut, ld, frc, imm, fire, rl, ex;
        int lv, rv;
        if (!rst_n) begin
            m_ec = 0; m_cnt = 0; m_pulse = 0; m_pend = 0;
            m_en = '0; m_flag = 0; m_cfg = '0; m_lo = '0; m_hi = '0;
            return;
        end
        sec  = (m_ec % TICK) == TICK - 1;
        mn   = sec && ((m_ec / TICK) % MDIV) == MDIV - 1;
        ut   = m_cfg[7] ? sec : mn;
        ld   = reg_we && (reg_addr == 2 || reg_addr == 3);
        lv   = (reg_addr == 2) ? {m_hi, reg_wdata} : {reg_wdata, m_lo};
        frc  = reg_we && reg_addr == 0 && reg_wdata[1];
        imm  = (gp_rd_stb && m_en[0]) || (kbd_irq && m_en[1]) || (mouse_irq && m_en[2]);
        fire = (m_pend == 1);
        rl   = imm || fire;
        rv   = {m_hi, m_lo};
        ex   = frc || (!ld && !rl && ut && m_cnt == 1);
        if (ld) m_cnt = lv;
        else if (frc) m_cnt = 0;
        else if (rl) m_cnt = rv;
        else if (ut && m_cnt != 0) m_cnt = m_cnt - 1;
        if (ir_irq && m_en[3]) m_pend = DLY;
        else if (m_pend > 0) m_pend = m_pend - 1;
        if (ex) m_pulse = PW;
        else if (m_pulse > 0) m_pulse = m_pulse - 1;
        if (ex) m_flag = 1;
        else if (reg_we && reg_addr == 0 && !reg_wdata[0]) m_flag = 0;
        if (reg_we) begin
            case (reg_addr)
                2'd0: m_en = reg_wdata[7:4];
                2'd1: m_cfg = reg_wdata;
                2'd2: m_lo = reg_wdata;
                default: m_hi = reg_wdata;
            endcase
        end
        m_ec++;
    endfunction

    function automatic int exp_rd();
        case (reg_addr)
            2'd0: return {m_en, 3'b000, m_flag};
            2'd1: return m_cfg;
            2'd2: return m_lo;
            default: return m_hi;
        endcase
    endfunction

    // model steps on the edge, compare 2 ns later
    always @(posedge clk) begin
        model_step();
        #2;
        if (!done) begin
            chk(cur_req, count_o, m_cnt, "count");
            chk(cur_req, {kb_reset_o, timeout_o, pwr_fail_o},
                {m_pulse > 0 && m_cfg[6], m_pulse > 0 && m_cfg[5], m_pulse > 0 && m_cfg[4]}, "pulses");
            chk(cur_req, reg_rdata, exp_rd(), "rdata");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk); reg_addr = a; #0.5;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_src(input int which);
        @(negedge clk);
        case (which)
            0: gp_rd_stb = 1'b1;
            1: kbd_irq = 1'b1;
            2: mouse_irq = 1'b1;
            default: ir_irq = 1'b1;
        endcase
        @(negedge clk);
        gp_rd_stb = 1'b0; kbd_irq = 1'b0; mouse_irq = 1'b0; ir_irq = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL %s watchdog expired actual=hung expected=finished", cur_req);
        finish_run();
    end

    initial begin
        cur_req = "R1";
        wait_cyc(3);
        chk("R1", count_o, 0, "reset count");
        chk("R1", {kb_reset_o, timeout_o, pwr_fail_o}, 0, "reset pulses");
        rst_n = 1'b1;
        rd(0); chk("R1", reg_rdata, 0, "reset ctrl");

        cur_req = "R2";
        wr(1, 8'hE5); rd(1); chk("R2", reg_rdata, 8'hE5, "cfg readback");
        wr(0, 8'hF0); rd(0); chk("R2", reg_rdata, 8'hF0, "ctrl enables");
        wr(0, 8'h0D); rd(0); chk("R2", reg_rdata, 8'h00, "ctrl bits 3:1 read zero");
        wr(3, 8'h00); rd(3); chk("R2", reg_rdata, 0, "high byte");

        cur_req = "R3";
        wr(2, 8'h03); chk("R3", count_o, 3, "load count");
        cur_req = "R5";
        wait_cyc(20);
        cur_req = "R6";
        wait_cyc(30); chk("R6", count_o, 0, "held at zero");

        cur_req = "R9";
        rd(0); chk("R9", reg_rdata, 8'h01, "flag set");
        wr(0, 8'h01); rd(0); chk("R9", reg_rdata, 8'h01, "flag kept by bit0=1");
        wr(0, 8'h00); rd(0); chk("R9", reg_rdata, 8'h00, "flag cleared");

        cur_req = "R3";
        wr(2, 8'h00); wait_cyc(20); chk("R3", count_o, 0, "zero stays stopped");

        cur_req = "R4";
        wr(1, 8'h50); wr(2, 8'h02);
        wait_cyc(2 * MDIV * TICK + 20); chk("R4", count_o, 0, "minute countdown done");

        cur_req = "R7";
        wr(1, 8'hF0); wr(2, 8'h06); wr(0, 8'h10);
        for (int i = 0; i < 8; i++) begin
            wait_cyc(10);
            pulse_src(0); chk("R7", count_o, 6, "game-port reload");
        end
        pulse_src(1); pulse_src(2); wait_cyc(40);

        cur_req = "R8";
        wr(2, 8'h05); wr(0, 8'h80);
        wait_cyc(12); pulse_src(3); wait_cyc(12);
        pulse_src(3); wait_cyc(2); pulse_src(3); wait_cyc(30);

        cur_req = "R10";
        wr(2, 8'h09); wait_cyc(3);
        wr(0, 8'h82); chk("R10", count_o, 0, "forced count");
        rd(0); chk("R10", reg_rdata, 8'h81, "force reads zero, flag set");
        wait_cyc(10);

        cur_req = "R11";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_we    = ($urandom % 30) == 0;
            reg_addr  = 2'($urandom % 4);
            reg_wdata = 8'($urandom);
            if (reg_addr == 2) reg_wdata = 8'($urandom % 12);
            if (reg_addr == 3) reg_wdata = 8'h00;
            if (reg_addr == 1) reg_wdata[7] = 1'b1;
            gp_rd_stb = ($urandom % 25) == 0;
            kbd_irq   = ($urandom % 25) == 0;
            mouse_irq = ($urandom % 25) == 0;
            ir_irq    = ($urandom % 25) == 0;
        end
        @(negedge clk);
        reg_we = 1'b0; gp_rd_stb = 1'b0; kbd_irq = 1'b0; mouse_irq = 1'b0; ir_irq = 1'b0;
        wait_cyc(4);
        finish_run();
    end
endmodule